// File: doc/BRIEF.md
# Configuration Frame ECC Generator

The block computes the 13-bit error-correction code that lives inside each configuration frame of 101 words of 32 bits. Frame words are presented one per clock together with their word index; words may come with idle cycles between them and in any cycle a word is flagged valid. Every set data bit adds its own positional code into a running XOR accumulator. The code for a bit depends on the word index and on the bit position, with three code bases chosen so that certain code values are never produced.

Word 50 is the word that holds the ECC field. Its low 13 bits are treated as zero while the code is being built. After word 100, the last word, the accumulator is finished with an overall parity bit. The block then presents the final code and a patched copy of word 50 that carries the new code in its low 13 bits and its own upper 19 bits unchanged. Both stay on the outputs, with a completion flag, until the next frame starts.

Top module: `frame_ecc_gen`

## Requirements
- R1: For every valid word with index w (0 to 100) and every set data bit b (0 to 31), the value w*32 + B + b, taken to 13 bits, is XORed into the accumulator, where B is 0x1320 for w up to 6, 0x1340 for w from 7 to 37 and 0x1360 for w of 38 or more.
- R2: In word 50 the data bits [12:0] are treated as zero; changing only those bits never changes the final code.
- R3: When word 100 is accepted, the final code equals the accumulated value with bit 12 replaced by bit 12 XOR the XOR of bits [11:0]; a frame whose only set bit is bit 0 of word 0 gives 0x0320, and one whose only set bit is bit 31 of word 100 gives 0x1FFF.
- R4: patched_word_o holds bits [31:13] of the last word 50 accepted in the frame, with the final code in bits [12:0].
- R5: A frame starts when start_i is high or a valid word with index 0 is accepted; the start clears the accumulator (and the kept upper bits of word 50) before that cycle's word contributes, so a frame may omit word 0 when start_i is used.
- R6: Cycles with word_vld_i low change neither the accumulator nor the outputs; idle gaps between words leave the final code unchanged.
- R7: done_o goes high and ecc_o and patched_word_o take the new values one clock after word 100 is accepted; they then hold until a frame start, which drops done_o one clock later.
- R8: Valid words with an index above 100 are ignored: they neither start a frame nor change the accumulator or outputs.
- R9: During and right after reset done_o is 0, ecc_o is 0 and patched_word_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Explicit frame start, clears the accumulator |
| word_vld_i | input | 1 | A frame word is present this cycle |
| word_idx_i | input | 7 | Index of the word within the frame (0 to 100) |
| word_data_i | input | 32 | Frame word data |
| done_o | output | 1 | Final code available, held until the next frame start |
| ecc_o | output | 13 | Final 13-bit code of the last completed frame |
| patched_word_o | output | 32 | Word 50 with its low 13 bits replaced by the code |

## Verification
Single-bit frames placed on both sides of each code-base boundary (words 6/7 and 37/38) and at the two extremes tell a wrong base or offset apart from a wrong parity fold, with two extremes checked against hand-worked values. Frames that differ only in the low 13 bits of word 50 separate a correct field mask from a missing one, while the upper bits of that word are checked in the patched output. Random frames with random idle gaps, out-of-range indices inserted among the words, and starts by index 0 or by start_i with word 0 omitted distinguish correct gating and clearing from stale accumulator state; a hold window after completion shows the outputs do not drift.

// File: rtl/frame_ecc_pkg.sv
package frame_ecc_pkg;

    // Frame geometry
    localparam int WORD_W      = 32;
    localparam int FRAME_WORDS = 101;
    localparam int ECC_W       = 13;
    localparam int ECC_WORD    = 50;

    // Code base selection by word index
    localparam int LOW_LAST    = 6;
    localparam int MID_LAST    = 37;
    localparam int BASE_LOW    = 'h1320;
    localparam int BASE_MID    = 'h1340;
    localparam int BASE_HIGH   = 'h1360;

    // Derived
    localparam int IDX_W     = $clog2(FRAME_WORDS);
    localparam int LAST_WORD = FRAME_WORDS - 1;
    localparam int HI_W      = WORD_W - ECC_W;

    typedef logic [IDX_W-1:0]  widx_t;
    typedef logic [ECC_W-1:0]  code_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [HI_W-1:0]   hi_t;

    // Decoded view of one input cycle
    typedef struct packed {
        logic in_range;
        logic frame_clr;
        logic is_last;
        logic is_field;
    } beat_dec_t;

    function automatic int code_base(input widx_t idx);
        int unsigned w;
        w = int'(idx);
        if (w <= LOW_LAST)      return BASE_LOW;
        else if (w <= MID_LAST) return BASE_MID;
        else                    return BASE_HIGH;
    endfunction

    function automatic code_t bit_code(input widx_t idx, input int b);
        int v;
        v = int'(idx) * WORD_W + code_base(idx) + b;
        return code_t'(v);
    endfunction

    function automatic code_t fold_parity(input code_t a);
        code_t r;
        r = a;
        r[ECC_W-1] = a[ECC_W-1] ^ (^a[ECC_W-2:0]);
        return r;
    endfunction

endpackage

// File: rtl/fecc_contrib.sv
module fecc_contrib
    import frame_ecc_pkg::*;
(
    input  widx_t idx_i,
    input  word_t data_i,
    output code_t code_o
);

    localparam word_t FIELD_MASK = {{HI_W{1'b0}}, {ECC_W{1'b1}}};

    word_t data_m;
    code_t term [WORD_W];

    always_comb begin
        if (idx_i == widx_t'(ECC_WORD))
            data_m = data_i & ~FIELD_MASK;
        else
            data_m = data_i;
    end

    for (genvar b = 0; b < WORD_W; b++) begin : g_term
        assign term[b] = data_m[b] ? bit_code(idx_i, b) : '0;
    end

    always_comb begin
        code_o = '0;
        for (int b = 0; b < WORD_W; b++) begin
            code_o = code_o ^ term[b];
        end
    end

endmodule

// File: rtl/fecc_accum.sv
module fecc_accum
    import frame_ecc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr_i,
    input  logic  upd_i,
    input  logic  last_i,
    input  code_t contrib_i,
    output code_t fin_o,
    output code_t ecc_o,
    output logic  done_o
);

    code_t acc_q;
    code_t acc_base;
    code_t acc_nxt;
    code_t ecc_q;
    logic  done_q;

    always_comb begin
        acc_base = clr_i ? '0 : acc_q;
        acc_nxt  = upd_i ? (acc_base ^ contrib_i) : acc_base;
        fin_o    = fold_parity(acc_nxt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            ecc_q  <= '0;
            done_q <= 1'b0;
        end else begin
            acc_q <= acc_nxt;
            if (upd_i && last_i) begin
                ecc_q  <= fin_o;
                done_q <= 1'b1;
            end else if (clr_i) begin
                done_q <= 1'b0;
            end
        end
    end

    assign ecc_o  = ecc_q;
    assign done_o = done_q;

endmodule

// File: rtl/fecc_field_keep.sv
module fecc_field_keep
    import frame_ecc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic cap_i,
    input  hi_t  hi_i,
    output hi_t  hi_o
);

    hi_t hi_q;

    always_ff @(posedge clk) begin
        if (rst)        hi_q <= '0;
        else if (cap_i) hi_q <= hi_i;
        else if (clr_i) hi_q <= '0;
    end

    assign hi_o = hi_q;

endmodule

// File: rtl/frame_ecc_gen.sv
module frame_ecc_gen
    import frame_ecc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              word_vld_i,
    input  logic [IDX_W-1:0]  word_idx_i,
    input  logic [WORD_W-1:0] word_data_i,
    output logic              done_o,
    output logic [ECC_W-1:0]  ecc_o,
    output logic [WORD_W-1:0] patched_word_o
);

    beat_dec_t dec;
    code_t     contrib;
    code_t     fin;
    hi_t       hi_kept;
    word_t     patched_q;

    always_comb begin
        dec.in_range  = word_vld_i && (word_idx_i <= widx_t'(LAST_WORD));
        dec.frame_clr = start_i || (word_vld_i && (word_idx_i == '0));
        dec.is_last   = (word_idx_i == widx_t'(LAST_WORD));
        dec.is_field  = dec.in_range && (word_idx_i == widx_t'(ECC_WORD));
    end

    fecc_contrib u_contrib (
        .idx_i  (word_idx_i),
        .data_i (word_data_i),
        .code_o (contrib)
    );

    fecc_accum u_accum (
        .clk       (clk),
        .rst       (rst),
        .clr_i     (dec.frame_clr),
        .upd_i     (dec.in_range),
        .last_i    (dec.is_last),
        .contrib_i (contrib),
        .fin_o     (fin),
        .ecc_o     (ecc_o),
        .done_o    (done_o)
    );

    fecc_field_keep u_keep (
        .clk   (clk),
        .rst   (rst),
        .clr_i (dec.frame_clr),
        .cap_i (dec.is_field),
        .hi_i  (word_data_i[WORD_W-1:ECC_W]),
        .hi_o  (hi_kept)
    );

    always_ff @(posedge clk) begin
        if (rst)
            patched_q <= '0;
        else if (dec.in_range && dec.is_last)
            patched_q <= {hi_kept, fin};
    end

    assign patched_word_o = patched_q;

endmodule

// File: rtl/fecc_checker.sv
module fecc_checker
    import frame_ecc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              word_vld_i,
    input logic [IDX_W-1:0]  word_idx_i,
    input logic              done_o,
    input logic [ECC_W-1:0]  ecc_o,
    input logic [WORD_W-1:0] patched_word_o
);

    logic last_beat;
    logic start_beat;
    logic live_beat;

    assign last_beat  = word_vld_i && (word_idx_i == widx_t'(LAST_WORD));
    assign start_beat = start_i || (word_vld_i && (word_idx_i == '0));
    assign live_beat  = word_vld_i && (word_idx_i <= widx_t'(LAST_WORD));

    p_reset_state_r9: assert property (@(posedge clk)
        rst |=> (!done_o && ecc_o == '0 && patched_word_o == '0));

    p_done_after_last_r7: assert property (@(posedge clk) disable iff (rst)
        last_beat |=> done_o);

    p_done_rise_cause_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> $past(last_beat));

    p_start_drops_done_r5: assert property (@(posedge clk) disable iff (rst)
        (start_beat && !last_beat) |=> !done_o);

    p_idle_keeps_outputs_r6: assert property (@(posedge clk) disable iff (rst)
        (!start_i && !live_beat) |=> ($stable(done_o) && $stable(ecc_o) && $stable(patched_word_o)));

    p_patch_low_bits_r4: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (patched_word_o[ECC_W-1:0] == ecc_o));

endmodule

bind frame_ecc_gen fecc_checker u_fecc_checker (.*);

// File: tb/tb_frame_ecc_gen.sv
`timescale 1ns/1ps
module tb_frame_ecc_gen;
    import frame_ecc_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        word_vld_i = 1'b0;
    logic [6:0]  word_idx_i = '0;
    logic [31:0] word_data_i = '0;
    logic        done_o;
    logic [12:0] ecc_o;
    logic [31:0] patched_word_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] fr [101];

    always #2.5 clk = ~clk;

    frame_ecc_gen dut (
        .clk            (clk),
        .rst            (rst),
        .start_i        (start_i),
        .word_vld_i     (word_vld_i),
        .word_idx_i     (word_idx_i),
        .word_data_i    (word_data_i),
        .done_o         (done_o),
        .ecc_o          (ecc_o),
        .patched_word_o (patched_word_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int base_of(input int w);
        if (w <= 6)       return 'h1320;
        else if (w <= 37) return 'h1340;
        else              return 'h1360;
    endfunction

    // Expected code from the requirements (R1, R2, R3)
    function automatic logic [12:0] ref_ecc();
        logic [12:0] acc;
        logic [31:0] d;
        acc = '0;
        for (int w = 0; w < 101; w++) begin
            d = fr[w];
            if (w == 50) d = d & 32'hFFFF_E000;
            for (int b = 0; b < 32; b++) begin
                if (d[b]) acc = acc ^ 13'(w * 32 + base_of(w) + b);
            end
        end
        acc[12] = acc[12] ^ (^acc[11:0]);
        return acc;
    endfunction

    task automatic clear_frame();
        for (int w = 0; w < 101; w++) fr[w] = '0;
    endtask

    task automatic rand_frame();
        for (int w = 0; w < 101; w++) fr[w] = $urandom;
    endtask

    // Called at a negative edge; returns at the negative edge after word 100.
    task automatic send_frame(input bit via_start, input bit gaps, input bit junk, input bit skip0);
        if (via_start) begin
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            chk("R5 start_i drops done", 32'(done_o), 32'd0);
        end
        for (int w = 0; w < 101; w++) begin
            if (skip0 && w == 0) continue;
            word_vld_i  = 1'b1;
            word_idx_i  = 7'(w);
            word_data_i = fr[w];
            @(negedge clk);
            word_vld_i = 1'b0;
            if (w == 0) chk("R7 done drops at frame start", 32'(done_o), 32'd0);
            if (gaps) repeat ($urandom_range(0, 2)) @(negedge clk);
            if (junk && (w % 25 == 3)) begin
                word_vld_i  = 1'b1;
                word_idx_i  = 7'(101 + $urandom_range(0, 26));
                word_data_i = $urandom;
                @(negedge clk);
                word_vld_i = 1'b0;
            end
        end
    endtask

    task automatic expect_frame(input string tag);
        logic [12:0] e;
        e = ref_ecc();
        chk({tag, " done"}, 32'(done_o), 32'd1);
        chk({tag, " ecc"}, 32'(ecc_o), 32'(e));
        chk({tag, " patched R4"}, patched_word_o, {fr[50][31:13], e});
    endtask

    initial begin
        #(5.0 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [12:0] e1;
        int singles_w [4];
        int singles_b [4];
        void'($urandom(32'd20240611));

        // R9 reset values
        repeat (3) @(negedge clk);
        chk("R9 reset done", 32'(done_o), 32'd0);
        chk("R9 reset ecc", 32'(ecc_o), 32'd0);
        chk("R9 reset patched", patched_word_o, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // R3 hand values: lowest code and highest code
        clear_frame();
        fr[0] = 32'h0000_0001;
        send_frame(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R3 word0 bit0 hand value", 32'(ecc_o), 32'h0320);
        chk("R1 word0 bit0 patched R4", patched_word_o, 32'h0000_0320);

        clear_frame();
        fr[100] = 32'h8000_0000;
        send_frame(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R3 word100 bit31 hand value", 32'(ecc_o), 32'h1FFF);

        // R1 base boundaries
        singles_w = '{6, 7, 37, 38};
        singles_b = '{31, 0, 31, 0};
        for (int k = 0; k < 4; k++) begin
            clear_frame();
            fr[singles_w[k]] = 32'h1 << singles_b[k];
            send_frame(1'b0, 1'b0, 1'b0, 1'b0);
            expect_frame("R1 base boundary");
        end

        // R2 masked field only
        clear_frame();
        fr[50] = 32'h0000_1FFF;
        send_frame(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R2 masked field ecc", 32'(ecc_o), 32'd0);
        chk("R2 masked field patched", patched_word_o, 32'd0);

        // R2 low bits of word 50 do not matter; R6 gaps
        rand_frame();
        send_frame(1'b0, 1'b0, 1'b0, 1'b0);
        expect_frame("R1 random");
        e1 = ecc_o;
        fr[50] = {fr[50][31:13], ~fr[50][12:0]};
        send_frame(1'b0, 1'b1, 1'b0, 1'b0);
        chk("R2 field low bits ignored", 32'(ecc_o), 32'(e1));
        expect_frame("R6 gaps");

        // R7 hold and R8 out-of-range words after completion
        repeat (4) @(negedge clk);
        word_vld_i  = 1'b1;
        word_idx_i  = 7'd127;
        word_data_i = 32'hFFFF_FFFF;
        @(negedge clk);
        word_vld_i = 1'b0;
        repeat (5) @(negedge clk);
        chk("R7 done held", 32'(done_o), 32'd1);
        chk("R8 ecc held after idx 127", 32'(ecc_o), 32'(e1));
        chk("R8 patched held", patched_word_o, {fr[50][31:13], e1});

        // R5 start_i clears stale partial sums; word 0 omitted
        word_vld_i  = 1'b1;
        word_idx_i  = 7'd3;
        word_data_i = 32'hDEAD_BEEF;
        @(negedge clk);
        word_vld_i = 1'b0;
        rand_frame();
        fr[0] = '0;
        send_frame(1'b1, 1'b1, 1'b0, 1'b1);
        expect_frame("R5 start_i frame");

        // Random mix: R6 gaps, R8 junk indices, R5 both start forms
        for (int n = 0; n < 24; n++) begin
            bit vs;
            bit gp;
            bit jk;
            rand_frame();
            if (n % 5 == 0) fr[50] = fr[50] | 32'h0000_1FFF;
            vs = bit'($urandom_range(0, 1));
            gp = bit'($urandom_range(0, 1));
            jk = bit'($urandom_range(0, 1));
            send_frame(vs, gp, jk, 1'b0);
            expect_frame("R8 random mix");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule